// File: doc/BRIEF.md
# Charger Protection Fault Sequencer

This block decides, cycle by cycle, whether the external charging pass switch may conduct. It receives already-debounced comparator flags from the analog front end: input power good, input over-voltage, battery over-voltage, over-temperature and reverse-blocking lockout. Each flag is asynchronous to the control clock. The block also receives a host switch request, which is synchronous to the clock, and a one-cycle tick pulse that marks each microsecond. It drives one registered gate-enable output. It also reports the accepted battery over-voltage event count, a latched-off indication and a mask of the causes currently holding the switch off.

All timing is counted in ticks. There is a power-on blanking period, a recovery period after input over-voltage, and a persistence window that a battery over-voltage flag must fill before it counts. Battery over-voltage events accumulate. When the count reaches its limit, the switch stays off until input power is lost and comes back. Losing input power clears every piece of fault state and starts the power-on blanking again.

Top module: `chg_guard_seq`

## Requirements
- R1: During and immediately after reset, gate_en is 0, fault_count is 0, latched_off is 0 and hold_mask is 7'b0000001.
- R2: After the synchronized power-good flag rises, gate_en stays 0 until POR_TICKS ticks have been counted. With a tick every cycle, gate_en rises on the (POR_TICKS+3)th rising edge after the raw flag rises.
- R3: A raised input over-voltage flag forces gate_en to 0 on the third rising edge after the raw flag rises.
- R4: After the input over-voltage flag clears, gate_en stays 0 until RECOV_TICKS ticks of continuous clearance have passed. A reassertion during that window restarts the count.
- R5: A battery over-voltage flag is accepted only after it has stayed high for BOVP_TICKS consecutive ticks. Shorter pulses change neither gate_en nor fault_count.
- R6: When an accepted battery over-voltage flag clears, gate_en returns on the fourth rising edge after the raw flag falls, with no added recovery period, provided nothing else holds it off.
- R7: Each accepted battery over-voltage event adds 1 to fault_count. At LATCH_EVENTS, latched_off becomes 1 and gate_en stays 0 whatever the other flags do. fault_count never exceeds LATCH_EVENTS.
- R8: While the synchronized power-good flag is low, gate_en is 0, fault_count is cleared to 0 and latched_off is cleared. When power good returns, the blanking period of R2 runs again.
- R9: The over-temperature flag forces gate_en to 0 while it is high. When it clears, gate_en returns on its own.
- R10: The reverse-lockout flag forces gate_en to 0. When no cause holds the switch off, gate_en equals host_req as sampled at the previous rising edge.
- R11: hold_mask bit positions are: 0 no input power, 1 power-on blanking, 2 input over-voltage or its recovery, 3 accepted battery over-voltage, 4 over-temperature, 5 reverse lockout, 6 latched off. The mask is registered alongside gate_en.
- R12: Every fault flag passes through a two-flop synchronizer, and gate_en is registered. Under any mix of flags, ticks and host requests, the outputs follow R2 to R11 with that latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_us | input | 1 | One-cycle pulse per microsecond, synchronous to clk |
| pwr_good_a | input | 1 | Raw input power-good flag (asynchronous) |
| in_ovp_a | input | 1 | Raw input over-voltage flag (asynchronous) |
| bat_ovp_a | input | 1 | Raw battery over-voltage flag (asynchronous) |
| over_temp_a | input | 1 | Raw over-temperature flag (asynchronous) |
| rev_lock_a | input | 1 | Raw reverse-blocking lockout flag (asynchronous) |
| host_req | input | 1 | Host request to close the switch, synchronous to clk |
| gate_en | output | 1 | Registered pass-switch enable |
| fault_count | output | CNT_W | Accepted battery over-voltage events since power-up |
| latched_off | output | 1 | Event limit reached; switch held off until power cycles |
| hold_mask | output | 7 | Causes currently holding the switch off (bit map in R11) |

## Verification
The bench builds the block with POR_TICKS=20, RECOV_TICKS=15 and BOVP_TICKS=6, and leaves LATCH_EVENTS at 16. These short windows let directed sequences cross each window boundary exactly, and let a run reach the sixteen-event latch several times. The random phase toggles power good, so the latch is set and cleared repeatedly, while random tick gaps stretch every window. Battery pulse lengths are drawn on both sides of the six-tick persistence limit.

// File: rtl/chg_guard_pkg.sv
package chg_guard_pkg;
  localparam int HOLD_W      = 7;
  localparam int HB_NOPWR    = 0;
  localparam int HB_BLANK    = 1;
  localparam int HB_INOVP    = 2;
  localparam int HB_BATOVP   = 3;
  localparam int HB_HOT      = 4;
  localparam int HB_REVLOCK  = 5;
  localparam int HB_LATCHED  = 6;

  localparam int NFLAGS      = 5;
  localparam int FL_PG       = 0;
  localparam int FL_INOVP    = 1;
  localparam int FL_BATOVP   = 2;
  localparam int FL_HOT      = 3;
  localparam int FL_REV      = 4;

  typedef logic [HOLD_W-1:0] hold_t;
endpackage

// File: rtl/cg_sync2.sv
module cg_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q[i] <= 1'b0;
          stab_q[i] <= 1'b0;
        end else begin
          meta_q[i] <= d[i];
          stab_q[i] <= meta_q[i];
        end
      end
    end
  endgenerate

  assign q = stab_q;
endmodule

// File: rtl/cg_tick_timer.sv
module cg_tick_timer #(
  parameter int LIMIT         = 8,
  parameter bit FULL_AT_RESET = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic load_full,
  input  logic clr,
  output logic done,
  output logic last_step
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] FULL = TW'(LIMIT);
  localparam logic [TW-1:0] PENU = TW'(LIMIT - 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_full) begin
      cnt_en = 1'b1;
      cnt_d  = FULL;
    end else if (clr) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (tick && (cnt_q != FULL)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= FULL_AT_RESET ? FULL : '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done      = (cnt_q == FULL);
  assign last_step = tick && !clr && !load_full && (cnt_q == PENU);
endmodule

// File: rtl/cg_evt_count.sv
module cg_evt_count #(
  parameter int MAX = 16,
  parameter int W   = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         full
);
  localparam logic [W-1:0] TOP = W'(MAX);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (inc && (cnt_q != TOP)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt  = cnt_q;
  assign full = (cnt_q == TOP);
endmodule

// File: rtl/chg_guard_seq.sv
module chg_guard_seq
  import chg_guard_pkg::*;
#(
  parameter int POR_TICKS    = 8000,
  parameter int RECOV_TICKS  = 8000,
  parameter int BOVP_TICKS   = 176,
  parameter int LATCH_EVENTS = 16,
  parameter int CNT_W        = $clog2(LATCH_EVENTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic              pwr_good_a,
  input  logic              in_ovp_a,
  input  logic              bat_ovp_a,
  input  logic              over_temp_a,
  input  logic              rev_lock_a,
  input  logic              host_req,
  output logic              gate_en,
  output logic [CNT_W-1:0]  fault_count,
  output logic              latched_off,
  output logic [HOLD_W-1:0] hold_mask
);
  logic [NFLAGS-1:0] flags_raw;
  logic [NFLAGS-1:0] flags_s;
  logic pg_s, iov_s, bov_s, hot_s, rev_s;

  assign flags_raw[FL_PG]     = pwr_good_a;
  assign flags_raw[FL_INOVP]  = in_ovp_a;
  assign flags_raw[FL_BATOVP] = bat_ovp_a;
  assign flags_raw[FL_HOT]    = over_temp_a;
  assign flags_raw[FL_REV]    = rev_lock_a;

  cg_sync2 #(.W(NFLAGS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (flags_raw),
    .q    (flags_s)
  );

  assign pg_s  = flags_s[FL_PG];
  assign iov_s = flags_s[FL_INOVP];
  assign bov_s = flags_s[FL_BATOVP];
  assign hot_s = flags_s[FL_HOT];
  assign rev_s = flags_s[FL_REV];

  logic blank_done, blank_last;
  logic recov_done, recov_last;
  logic bov_done,   bov_last;
  logic cnt_full;
  logic [CNT_W-1:0] cnt_val;

  // Power-on blanking: counts up while power is good, cleared on loss.
  cg_tick_timer #(.LIMIT(POR_TICKS), .FULL_AT_RESET(1'b0)) u_blank (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_us),
    .load_full(1'b0),
    .clr      (!pg_s),
    .done     (blank_done),
    .last_step(blank_last)
  );

  // Over-voltage recovery: zeroed while the flag is high, preset on power loss
  // so that only the blanking window applies after power-up.
  cg_tick_timer #(.LIMIT(RECOV_TICKS), .FULL_AT_RESET(1'b1)) u_recov (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_us),
    .load_full(!pg_s),
    .clr      (iov_s),
    .done     (recov_done),
    .last_step(recov_last)
  );

  // Battery over-voltage persistence window.
  cg_tick_timer #(.LIMIT(BOVP_TICKS), .FULL_AT_RESET(1'b0)) u_bovp (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_us),
    .load_full(1'b0),
    .clr      (!pg_s || !bov_s),
    .done     (bov_done),
    .last_step(bov_last)
  );

  // Accepted events: one per completed persistence window.
  cg_evt_count #(.MAX(LATCH_EVENTS), .W(CNT_W)) u_evt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!pg_s),
    .inc  (bov_last),
    .cnt  (cnt_val),
    .full (cnt_full)
  );

  hold_t hold_d;
  hold_t hold_q;
  logic  gate_d;
  logic  gate_q;

  always_comb begin
    hold_d             = '0;
    hold_d[HB_NOPWR]   = !pg_s;
    hold_d[HB_BLANK]   = pg_s && !blank_done;
    hold_d[HB_INOVP]   = pg_s && (iov_s || !recov_done);
    hold_d[HB_BATOVP]  = pg_s && bov_done;
    hold_d[HB_HOT]     = hot_s;
    hold_d[HB_REVLOCK] = rev_s;
    hold_d[HB_LATCHED] = cnt_full;
    gate_d             = host_req && (hold_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= hold_t'(1 << HB_NOPWR);
      gate_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      gate_q <= gate_d;
    end
  end

  assign gate_en     = gate_q;
  assign hold_mask   = hold_q;
  assign fault_count = cnt_val;
  assign latched_off = cnt_full;

  logic unused_ok;
  assign unused_ok = blank_last ^ recov_last;
endmodule

// File: rtl/chg_guard_chk.sv
module chg_guard_chk #(
  parameter int LATCH_EVENTS = 16,
  parameter int CNT_W        = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pg_s,
  input logic             iov_s,
  input logic             hot_s,
  input logic             host_req,
  input logic             gate_en,
  input logic [CNT_W-1:0] fault_count,
  input logic             latched_off
);
  // R7
  latch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latched_off |=> !gate_en);

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_count <= CNT_W'(LATCH_EVENTS));

  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_count != $past(fault_count)) |->
      ((fault_count == $past(fault_count) + 1'b1) || (fault_count == '0)));

  // R8
  pgloss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_s |=> ((fault_count == '0) && !latched_off && !gate_en));

  // R3
  inovp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iov_s |=> !gate_en);

  // R9
  hot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hot_s |=> !gate_en);

  // R10
  host_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en |-> $past(host_req));
endmodule

bind chg_guard_seq chg_guard_chk #(
  .LATCH_EVENTS(LATCH_EVENTS),
  .CNT_W       (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pg_s       (pg_s),
  .iov_s      (iov_s),
  .hot_s      (hot_s),
  .host_req   (host_req),
  .gate_en    (gate_en),
  .fault_count(fault_count),
  .latched_off(latched_off)
);

// File: tb/test_chg_guard_seq.sv
module test_chg_guard_seq;
  localparam int POR   = 20;
  localparam int RECOV = 15;
  localparam int BOVP  = 6;
  localparam int LATCH = 16;
  localparam int CW    = $clog2(LATCH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b1;
  logic pwr_good_a = 1'b0, in_ovp_a = 1'b0, bat_ovp_a = 1'b0;
  logic over_temp_a = 1'b0, rev_lock_a = 1'b0, host_req = 1'b1;
  logic gate_en, latched_off;
  logic [CW-1:0] fault_count;
  logic [6:0] hold_mask;

  always #10 clk = ~clk;

  chg_guard_seq #(
    .POR_TICKS(POR), .RECOV_TICKS(RECOV), .BOVP_TICKS(BOVP), .LATCH_EVENTS(LATCH)
  ) i_chg_guard_seq (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
    .pwr_good_a(pwr_good_a), .in_ovp_a(in_ovp_a), .bat_ovp_a(bat_ovp_a),
    .over_temp_a(over_temp_a), .rev_lock_a(rev_lock_a), .host_req(host_req),
    .gate_en(gate_en), .fault_count(fault_count), .latched_off(latched_off),
    .hold_mask(hold_mask)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  string cur_req = "R1";

  // Reference model built from the requirements
  logic [4:0] m_s1, m_s2;
  int m_pb, m_rc, m_bc, m_cnt;
  logic m_gate;
  logic [6:0] m_hold;

  function automatic logic [6:0] exp_hold(logic [4:0] s, int pb, int rc, int bc, int cnt);
    logic [6:0] h;
    h[0] = !s[0];
    h[1] = s[0] && (pb != POR);
    h[2] = s[0] && (s[1] || rc != RECOV);
    h[3] = s[0] && (bc == BOVP);
    h[4] = s[3];
    h[5] = s[4];
    h[6] = (cnt == LATCH);
    return h;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_pb <= 0; m_rc <= RECOV; m_bc <= 0; m_cnt <= 0;
      m_gate <= 1'b0; m_hold <= 7'b0000001;
    end else begin
      logic [6:0] h;
      m_s1 <= {rev_lock_a, over_temp_a, bat_ovp_a, in_ovp_a, pwr_good_a};
      m_s2 <= m_s1;
      if (!m_s2[0]) m_pb <= 0;
      else if (tick_us && m_pb < POR) m_pb <= m_pb + 1;
      if (!m_s2[0]) m_rc <= RECOV;
      else if (m_s2[1]) m_rc <= 0;
      else if (tick_us && m_rc < RECOV) m_rc <= m_rc + 1;
      if (!m_s2[0] || !m_s2[2]) m_bc <= 0;
      else if (tick_us && m_bc < BOVP) m_bc <= m_bc + 1;
      if (!m_s2[0]) m_cnt <= 0;
      else if (m_s2[2] && tick_us && m_bc == BOVP - 1 && m_cnt < LATCH) m_cnt <= m_cnt + 1;
      h = exp_hold(m_s2, m_pb, m_rc, m_bc, m_cnt);
      m_hold <= h;
      m_gate <= host_req && (h == 0);
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(cur_req, "gate_en vs model", gate_en, m_gate);
      check(cur_req, "fault_count vs model", fault_count, m_cnt);
      check(cur_req, "latched_off vs model", latched_off, m_cnt == LATCH);
      check(cur_req, "hold_mask vs model", hold_mask, m_hold);
    end
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000 * 10) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "gate_en in reset", gate_en, 0);
    check("R1", "fault_count in reset", fault_count, 0);
    check("R1", "latched_off in reset", latched_off, 0);
    check("R1", "hold_mask in reset", hold_mask, 7'b0000001);
    rst_n = 1'b1;
    step(1);
    check("R1", "gate_en after reset", gate_en, 0);
    check("R1", "hold_mask after reset", hold_mask, 7'b0000001);

    // R2: power-on blanking
    cur_req = "R2";
    pwr_good_a = 1'b1;
    step(POR + 2);
    check("R2", "gate_en at end of blanking", gate_en, 0);
    check("R11", "blanking bit", hold_mask[1], 1);
    step(1);
    check("R2", "gate_en after blanking", gate_en, 1);

    // R3 / R4: input over-voltage and recovery restart
    cur_req = "R3";
    in_ovp_a = 1'b1;
    step(2);
    check("R3", "gate_en two edges after OVP", gate_en, 1);
    step(1);
    check("R3", "gate_en three edges after OVP", gate_en, 0);
    check("R11", "input OVP bit", hold_mask[2], 1);
    cur_req = "R4";
    in_ovp_a = 1'b0;
    step(5);
    in_ovp_a = 1'b1;
    step(1);
    in_ovp_a = 1'b0;
    step(RECOV + 2);
    check("R4", "gate_en before recovery ends", gate_en, 0);
    step(1);
    check("R4", "gate_en after recovery", gate_en, 1);

    // R5: short battery pulse ignored
    cur_req = "R5";
    bat_ovp_a = 1'b1;
    step(BOVP - 1);
    bat_ovp_a = 1'b0;
    step(8);
    check("R5", "gate_en after short pulse", gate_en, 1);
    check("R5", "fault_count after short pulse", fault_count, 0);
    bat_ovp_a = 1'b1;
    step(BOVP + 3);
    check("R5", "gate_en after accepted event", gate_en, 0);
    check("R5", "fault_count after accepted event", fault_count, 1);
    check("R11", "battery OVP bit", hold_mask[3], 1);

    // R6: immediate resume
    cur_req = "R6";
    bat_ovp_a = 1'b0;
    step(3);
    check("R6", "gate_en three edges after clear", gate_en, 0);
    step(1);
    check("R6", "gate_en four edges after clear", gate_en, 1);

    // R7: latch-off at limit
    cur_req = "R7";
    for (int k = 1; k < LATCH; k++) begin
      bat_ovp_a = 1'b1;
      step(BOVP + 3);
      bat_ovp_a = 1'b0;
      step(6);
    end
    check("R7", "fault_count at limit", fault_count, LATCH);
    check("R7", "latched_off at limit", latched_off, 1);
    check("R7", "gate_en when latched", gate_en, 0);
    check("R11", "latched bit", hold_mask[6], 1);
    bat_ovp_a = 1'b1;
    step(BOVP + 4);
    bat_ovp_a = 1'b0;
    step(6);
    check("R7", "fault_count saturates", fault_count, LATCH);

    // R8: power loss clears everything
    cur_req = "R8";
    pwr_good_a = 1'b0;
    step(4);
    check("R8", "fault_count after power loss", fault_count, 0);
    check("R8", "latched_off after power loss", latched_off, 0);
    check("R8", "gate_en after power loss", gate_en, 0);
    check("R11", "no-power bit", hold_mask[0], 1);
    pwr_good_a = 1'b1;
    step(POR + 2);
    check("R8", "gate_en during new blanking", gate_en, 0);
    step(1);
    check("R8", "gate_en after new blanking", gate_en, 1);

    // R9: over-temperature
    cur_req = "R9";
    over_temp_a = 1'b1;
    step(3);
    check("R9", "gate_en while hot", gate_en, 0);
    check("R11", "hot bit", hold_mask[4], 1);
    over_temp_a = 1'b0;
    step(3);
    check("R9", "gate_en after cooling", gate_en, 1);

    // R10: reverse lockout and host request
    cur_req = "R10";
    rev_lock_a = 1'b1;
    step(3);
    check("R10", "gate_en under lockout", gate_en, 0);
    check("R11", "lockout bit", hold_mask[5], 1);
    rev_lock_a = 1'b0;
    step(3);
    check("R10", "gate_en after lockout", gate_en, 1);
    host_req = 1'b0;
    step(1);
    check("R10", "gate_en follows host low", gate_en, 0);
    check("R11", "mask clear with host low", hold_mask, 0);
    host_req = 1'b1;
    step(1);
    check("R10", "gate_en follows host high", gate_en, 1);

    // R12: random mix checked against the model every cycle
    cur_req = "R12";
    for (int c = 0; c < 30000; c++) begin
      tick_us = ($urandom % 4) != 0;
      if ($urandom % 2000 == 0) pwr_good_a = ~pwr_good_a;
      else if (!pwr_good_a && $urandom % 30 == 0) pwr_good_a = 1'b1;
      if ($urandom % 400 == 0) in_ovp_a = ~in_ovp_a;
      else if (in_ovp_a && $urandom % 8 == 0) in_ovp_a = 1'b0;
      if ($urandom % (bat_ovp_a ? 9 : 40) == 0) bat_ovp_a = ~bat_ovp_a;
      if ($urandom % 600 == 0) over_temp_a = ~over_temp_a;
      else if (over_temp_a && $urandom % 20 == 0) over_temp_a = 1'b0;
      if ($urandom % 700 == 0) rev_lock_a = ~rev_lock_a;
      else if (rev_lock_a && $urandom % 20 == 0) rev_lock_a = 1'b0;
      host_req = ($urandom % 50) != 0;
      step(1);
    end
    finish_run();
  end
endmodule